// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Cycle Decoder

This block is a clocked front end for an asynchronous, strobe-driven DRAM port. A fast system clock oversamples the four active-low strobes (row strobe, column strobe, write enable, output enable). The block works out which kind of memory cycle the strobes describe from the order in which their edges arrive. It captures the row and column addresses on the right edges, runs an internal refresh row counter, and drives read, write and refresh command pulses and a data-drive enable. A small behavioural cell array, indexed by the low bits of row and column, stores and returns data so that a whole access can be exercised end to end.

Every strobe, address and data input passes through the same two-stage synchronizer, so all decisions are made on aligned, sampled values. A command pulse or a change of state appears three clock cycles after the input change that causes it. The cycle classification is visible on `cyc_kind`. The refresh row in use is visible on `ref_row` while `ref_pulse` is high.

Top module: `dram_cycle_decoder`

## Requirements
- R1: When the row strobe falls while the column strobe was high, the sampled address is latched and shown on `row_addr`.
- R2: Each column strobe fall while the row strobe is low latches a new column in the open row. With write enable high this is a read (`cyc_kind`=1, one `rd_pulse`), and the stored word appears on `dq_out`. Read, write and refresh pulses never coincide.
- R3: If write enable is low when the column strobe falls, the access is an early write (`cyc_kind`=2). The data pins are stored at that edge, and `dq_oe` stays low for the whole cycle.
- R4: If write enable falls while the column strobe is already low after a read, the access is a delayed write (`cyc_kind`=3). The data pins are stored at the write-enable edge, and that edge turns the output off.
- R5: If the column strobe is low before the row strobe falls, the cycle is a counter refresh (`cyc_kind`=5). One `ref_pulse` shows the counter value on `ref_row`, `row_addr` keeps its old value whatever the address pins hold, and `dq_oe` stays low.
- R6: The 11-bit refresh counter starts at 0, advances by one after each counter refresh, and wraps from 2047 to 0.
- R7: A row-strobe low period with no column strobe fall is an address refresh (`cyc_kind`=4). At the row-strobe rise, one `ref_pulse` shows the latched row on `ref_row`, and the refresh counter does not move.
- R8: If the column strobe is held low after a read while the row strobe rises and falls again, each new row-strobe fall is a counter refresh, and the read data stays driven on the data pins.
- R9: Read data stays driven after the column strobe rises while the row strobe is low. It is turned off once both strobes are high, and output enable high masks it.
- R10: Row and column strobes falling in the same sample count as a row activation followed at once by a column access using the same address, never as a refresh.
- R11: After reset, `dq_oe`, all pulses, `cyc_kind`, `row_addr`, `col_addr` and `ref_row` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 11 | Multiplexed row/column address |
| dq_in | input | 4 | Write data from the pins |
| dq_out | output | 4 | Read data toward the pins |
| dq_oe | output | 1 | Pin drive enable for dq_out |
| row_addr | output | 11 | Latched row |
| col_addr | output | 11 | Latched column |
| cyc_kind | output | 3 | 0 idle, 1 read, 2 early write, 3 delayed write, 4 address refresh, 5 counter refresh |
| rd_pulse | output | 1 | One-cycle read command |
| wr_pulse | output | 1 | One-cycle write command |
| ref_pulse | output | 1 | One-cycle refresh command |
| ref_row | output | 11 | Row refreshed by the last refresh |

## Verification
A wrong internal flag shows up as the wrong `cyc_kind` and the wrong pulse about three cycles after the offending strobe edge. For example, a stale row-open flag turns an address refresh into nothing, and a lost column-seen flag adds an address refresh. A refresh counter that is off by one shows up at the next counter refresh on `ref_row`, and the full wrap sweep exposes a width or wrap error. A wrongly kept data-valid flag leaves `dq_oe` high one cycle after both strobes are seen high, or during an early write.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_READ = 3'd1,
    CYC_EWR  = 3'd2,
    CYC_DWR  = 3'd3,
    CYC_ROR  = 3'd4,
    CYC_CBR  = 3'd5
  } cyc_e;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d_in;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcd_cell_array.sv
module dcd_cell_array #(
  parameter int IDX_W = 6,
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/dcd_cycle_ctrl.sv
module dcd_cycle_ctrl
  import dcd_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_ras,
  input  logic          s_cas,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_dq,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output cyc_e          cyc_q,
  output logic          rd_p,
  output logic          wr_p,
  output logic          ref_p,
  output logic [AW-1:0] ref_row_q,
  output logic [DW-1:0] wr_data_q,
  output logic          data_valid
);
  logic          ras_prev, cas_prev, we_prev;
  logic          ras_fall, ras_rise, cas_fall, we_fall, cas_eff;
  logic          cas_pend, in_row, col_seen, early;
  logic [AW-1:0] ref_cnt;

  assign ras_fall = ras_prev & ~s_ras;
  assign ras_rise = ~ras_prev & s_ras;
  assign cas_fall = cas_prev & ~s_cas;
  assign we_fall  = we_prev & ~s_we;
  // a column fall sharing a sample with a row fall is replayed one cycle later
  assign cas_eff  = (cas_fall & ~ras_fall) | cas_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev   <= 1'b1;
      cas_prev   <= 1'b1;
      we_prev    <= 1'b1;
      cas_pend   <= 1'b0;
      in_row     <= 1'b0;
      col_seen   <= 1'b0;
      early      <= 1'b0;
      ref_cnt    <= '0;
      row_q      <= '0;
      col_q      <= '0;
      cyc_q      <= CYC_IDLE;
      rd_p       <= 1'b0;
      wr_p       <= 1'b0;
      ref_p      <= 1'b0;
      ref_row_q  <= '0;
      wr_data_q  <= '0;
      data_valid <= 1'b0;
    end else begin
      ras_prev <= s_ras;
      cas_prev <= s_cas;
      we_prev  <= s_we;
      rd_p     <= 1'b0;
      wr_p     <= 1'b0;
      ref_p    <= 1'b0;
      cas_pend <= cas_fall & ras_fall;

      if (rd_p) data_valid <= 1'b1;

      if (ras_fall) begin
        if (!cas_prev) begin
          ref_p     <= 1'b1;
          ref_row_q <= ref_cnt;
          ref_cnt   <= ref_cnt + 1'b1;
          cyc_q     <= CYC_CBR;
          in_row    <= 1'b0;
        end else begin
          in_row   <= 1'b1;
          col_seen <= 1'b0;
          row_q    <= s_addr;
        end
      end

      if (ras_rise) begin
        if (in_row && !col_seen) begin
          ref_p     <= 1'b1;
          ref_row_q <= row_q;
          cyc_q     <= CYC_ROR;
        end
        in_row <= 1'b0;
        early  <= 1'b0;
      end

      if (cas_eff && in_row && !s_ras) begin
        col_q    <= s_addr;
        col_seen <= 1'b1;
        if (!s_we) begin
          wr_p       <= 1'b1;
          wr_data_q  <= s_dq;
          early      <= 1'b1;
          cyc_q      <= CYC_EWR;
          data_valid <= 1'b0;
        end else begin
          rd_p  <= 1'b1;
          early <= 1'b0;
          cyc_q <= CYC_READ;
        end
      end

      if (we_fall && in_row && !s_ras && !s_cas && !cas_eff && !early) begin
        wr_p       <= 1'b1;
        wr_data_q  <= s_dq;
        cyc_q      <= CYC_DWR;
        data_valid <= 1'b0;
      end

      if (s_ras && s_cas) data_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 4,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic [2:0]    cyc_kind,
  output logic          rd_pulse,
  output logic          wr_pulse,
  output logic          ref_pulse,
  output logic [AW-1:0] ref_row
);
  localparam int IDX_W = ROW_IDX_W + COL_IDX_W;
  localparam int SW = 4 + AW + DW;

  logic [SW-1:0] raw_bus, s_bus;
  logic          ras_s, cas_s, we_s, oe_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] dq_s, wr_data, rd_word;
  logic          data_valid;
  cyc_e          cyc;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign raw_bus = {ras_n, cas_n, we_n, oe_n, addr, dq_in};

  dcd_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({4'b1111, {(AW+DW){1'b0}}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_bus), .q(s_bus)
  );

  assign {ras_s, cas_s, we_s, oe_s, addr_s, dq_s} = s_bus;

  dcd_cycle_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_ras(ras_s), .s_cas(cas_s), .s_we(we_s),
    .s_addr(addr_s), .s_dq(dq_s),
    .row_q(row_addr), .col_q(col_addr), .cyc_q(cyc),
    .rd_p(rd_pulse), .wr_p(wr_pulse), .ref_p(ref_pulse),
    .ref_row_q(ref_row), .wr_data_q(wr_data), .data_valid(data_valid)
  );

  assign rd_idx = {row_addr[ROW_IDX_W-1:0], col_addr[COL_IDX_W-1:0]};
  assign wr_idx = rd_idx;

  dcd_cell_array #(.IDX_W(IDX_W), .DW(DW)) u_cells (
    .clk(clk), .wr_en(wr_pulse), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq_out <= '0;
    else if (rd_pulse) dq_out <= rd_word;
  end

  assign dq_oe    = data_valid & ~oe_s;
  assign cyc_kind = cyc;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_s,
  input logic          cas_s,
  input logic          dq_oe,
  input logic [2:0]    cyc_kind,
  input logic          rd_pulse,
  input logic          wr_pulse,
  input logic          ref_pulse,
  input logic [AW-1:0] ref_row,
  input logic [AW-1:0] row_addr
);
  logic [AW-1:0] cbr_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cbr_exp <= '0;
    else if (ref_pulse && cyc_kind == 3'd5) cbr_exp <= cbr_exp + 1'b1;
  end

  assert_cmd_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pulse, wr_pulse, ref_pulse}));

  assert_early_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd2) |-> !dq_oe);

  assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && cyc_kind == 3'd5) |-> ref_row == cbr_exp);

  assert_ror_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && cyc_kind == 3'd4) |-> ref_row == row_addr);

  assert_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_s && cas_s) |=> !dq_oe);

  always_comb begin
    if (!rst_n) assert_reset_quiet_R11: assert (!rd_pulse && !wr_pulse && !ref_pulse);
  end
endmodule

bind dram_cycle_decoder dcd_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .cas_s(cas_s), .dq_oe(dq_oe),
  .cyc_kind(cyc_kind), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
  .ref_pulse(ref_pulse), .ref_row(ref_row), .row_addr(row_addr)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [3:0]  dq_in = '0;
  logic [3:0]  dq_out;
  logic        dq_oe, rd_pulse, wr_pulse, ref_pulse;
  logic [10:0] row_addr, col_addr, ref_row;
  logic [2:0]  cyc_kind;

  int checks = 0, failures = 0;
  int n_rd = 0, n_wr = 0, n_ref = 0;
  bit done = 0;
  logic [3:0] model [64];
  logic [10:0] exp_cnt = '0;

  always #5 clk = ~clk;

  dram_cycle_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .row_addr(row_addr), .col_addr(col_addr), .cyc_kind(cyc_kind),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .ref_pulse(ref_pulse),
    .ref_row(ref_row)
  );

  always @(posedge clk) if (rst_n) begin
    if (rd_pulse) n_rd++;
    if (wr_pulse) n_wr++;
    if (ref_pulse) n_ref++;
  end

  function automatic logic [3:0] pat(int r, int c);
    return 4'((r * 3 + c * 5 + 1) & 15);
  endfunction
  function automatic logic [10:0] row_pin(int r);
    return 11'(r | (r << 8));
  endfunction
  function automatic logic [10:0] col_pin(int c);
    return 11'(c | (c << 5));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ref0, wr0, rd0;
    for (int i = 0; i < 64; i++) model[i] = 'x;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dq_oe == 0 && cyc_kind == 0, "R11 reset outputs", {dq_oe, cyc_kind}, 0);
    chk(row_addr == 0 && col_addr == 0 && ref_row == 0, "R11 reset addresses", row_addr | col_addr | ref_row, 0);
    rst_n = 1'b1;
    step();

    // R1 R3 early-write sweep in page mode
    for (int r = 0; r < 8; r++) begin
      addr = row_pin(r); step();
      ras_n = 0; step();
      chk(row_addr == row_pin(r), "R1 row latch", row_addr, row_pin(r));
      we_n = 0;
      for (int c = 0; c < 8; c++) begin
        wr0 = n_wr;
        addr = col_pin(c); dq_in = pat(r, c); step();
        cas_n = 0; step();
        model[r*8+c] = pat(r, c);
        chk(cyc_kind == 2 && n_wr == wr0 + 1, "R3 early write kind", cyc_kind, 2);
        chk(dq_oe == 0, "R3 early write quiet", dq_oe, 0);
        cas_n = 1; step();
      end
      we_n = 1; ras_n = 1; step();
    end

    // R2 R9 page-mode read sweep
    oe_n = 0;
    for (int r = 0; r < 8; r++) begin
      addr = row_pin(r); step();
      ras_n = 0; step();
      for (int c = 0; c < 8; c++) begin
        rd0 = n_rd;
        addr = col_pin(c); step();
        cas_n = 0; step();
        chk(cyc_kind == 1 && n_rd == rd0 + 1 && col_addr == col_pin(c), "R2 read kind", cyc_kind, 1);
        chk(dq_oe == 1 && dq_out == pat(r, c), "R2 read data", dq_out, pat(r, c));
        cas_n = 1; step();
        chk(dq_oe == 1 && dq_out == pat(r, c), "R9 data held after column rise", dq_oe, 1);
      end
      ras_n = 1; step();
      chk(dq_oe == 0, "R9 off when both high", dq_oe, 0);
    end

    // R4 delayed write
    addr = row_pin(2); step(); ras_n = 0; step();
    addr = col_pin(3); step(); cas_n = 0; step();
    chk(dq_oe == 1 && dq_out == pat(2, 3), "R2 read before delayed write", dq_out, pat(2, 3));
    oe_n = 1; step();
    chk(dq_oe == 0, "R9 output enable masks", dq_oe, 0);
    oe_n = 0; dq_in = 4'hA; wr0 = n_wr; step();
    we_n = 0; step();
    model[2*8+3] = 4'hA;
    chk(cyc_kind == 3 && n_wr == wr0 + 1, "R4 delayed write kind", cyc_kind, 3);
    chk(dq_oe == 0, "R4 output turned off by write edge", dq_oe, 0);
    cas_n = 1; we_n = 1; ras_n = 1; step();
    addr = row_pin(2); ras_n = 0; step();
    addr = col_pin(3); cas_n = 0; step();
    chk(dq_out == 4'hA && dq_oe == 1, "R4 delayed data stored", dq_out, 4'hA);
    cas_n = 1; ras_n = 1; step();

    // R7 address refresh
    ref0 = n_ref; addr = 11'h5A5; step(); ras_n = 0; step();
    ras_n = 1; step();
    chk(n_ref == ref0 + 1 && cyc_kind == 4, "R7 address refresh kind", cyc_kind, 4);
    chk(ref_row == 11'h5A5 && dq_oe == 0, "R7 address refresh row", ref_row, 11'h5A5);

    // R8 hidden refresh
    addr = row_pin(1); step(); ras_n = 0; step();
    addr = col_pin(1); cas_n = 0; step();
    ras_n = 1; step();
    chk(dq_oe == 1 && dq_out == pat(1, 1), "R8 data held across row rise", dq_out, pat(1, 1));
    ref0 = n_ref; addr = 11'h7FF; ras_n = 0; step();
    chk(cyc_kind == 5 && n_ref == ref0 + 1 && ref_row == exp_cnt, "R8 hidden refresh row", ref_row, exp_cnt);
    chk(dq_oe == 1 && dq_out == pat(1, 1), "R8 data still driven", dq_out, pat(1, 1));
    exp_cnt++;
    ras_n = 1; cas_n = 1; step();
    chk(dq_oe == 0, "R9 off after hidden refresh", dq_oe, 0);

    // R10 simultaneous falls
    ref0 = n_ref; rd0 = n_rd; addr = 11'h404; step();
    ras_n = 0; cas_n = 0; step();
    chk(row_addr == 11'h404 && col_addr == 11'h404 && n_rd == rd0 + 1, "R10 activation plus column", row_addr, 11'h404);
    chk(n_ref == ref0 && cyc_kind == 1 && dq_out == model[4*8+4], "R10 no refresh", n_ref - ref0, 0);
    ras_n = 1; cas_n = 1; step();

    // R5 R6 counter refresh sweep across the wrap
    for (int i = 0; i < 2050; i++) begin
      logic [10:0] keep_row;
      keep_row = row_addr;
      ref0 = n_ref;
      addr = 11'(i * 37); cas_n = 0; step();
      ras_n = 0; step();
      chk(n_ref == ref0 + 1 && cyc_kind == 5 && ref_row == exp_cnt, "R6 counter refresh row", ref_row, exp_cnt);
      chk(row_addr == keep_row && dq_oe == 0, "R5 pins ignored, output off", row_addr, keep_row);
      exp_cnt++;
      ras_n = 1; step(); cas_n = 1; step();
    end
    chk(exp_cnt == 11'((2050 + 1) % 2048), "R6 wrap reached", exp_cnt, (2051) % 2048);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule